// File: doc/BRIEF.md
# Power Domain Control Unit

This block sequences the power state of up to 32 independently switchable logic domains on behalf of software. A small word-addressed register bus carries the commands. Writing a bitmask to one command register asks the marked domains to switch on, and writing a bitmask to another asks them to switch off. A status register shows which domains are asleep. Each domain has a request output and an acknowledge input. An external power switch, or a model of one, answers the request after its own delay. A domain's status bit moves only when that acknowledge has caught up with the request.

Software can learn that a transition has finished in two ways. It can poll the status register, or it can enable domains in an interrupt mask and wait for the single interrupt output. By convention bit 0 is the geometry engine and bit 1 is the shared cache. Bits 2 and upward are the pixel cores in ascending core order. The block itself treats every bit alike.

The register bus is plain control. It never stalls, so it has no ready signal. A write takes effect at the clock edge where `wr_en` is sampled. A read returns its data together with `rd_vld` one cycle after `rd_en`.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: Registers are chosen by byte offset `addr`, and the two lowest address bits are ignored. The offsets are 0x00 power-on command, 0x04 power-off command, 0x08 sleep status and 0x0C interrupt mask. Read data and `rd_vld` appear in the cycle after `rd_en`.
- R2: A write to 0x00 sets `pwr_req` to 1 for every domain whose data bit is 1. Domains whose bit is 0 keep their request.
- R3: A write to 0x04 sets `pwr_req` to 0 for every domain whose data bit is 1. Domains whose bit is 0 keep their request.
- R4: In the status register, bit i reads 1 while domain i is asleep and 0 while it is powered. The bit changes only after `pwr_ack[i]` equals `pwr_req[i]`, and it then takes the value of the inverted acknowledge.
- R5: While the interrupt mask is 0, `irq` stays low.
- R6: A later command to a domain replaces an earlier one that has not yet completed. A command that asks for the state a domain already has completes at once. It leaves nothing pending and is not counted as a completion.
- R7: A sticky flag is set when a domain enabled in the mask completes its transition and, as a result, no enabled domain is still pending. `irq` equals this flag ANDed with a nonzero mask.
- R8: Any write to either command register clears the flag. A completion in the same cycle takes precedence over the clear.
- R9: Both command registers read back as 0. The status and mask registers read back their current values.
- R10: Offsets 0x10 and above read as 0, and writes to them change nothing.
- R11: After reset every domain reads asleep, `pwr_req` is 0, nothing is pending, the mask is 0 and `irq` is 0.
- R12: Bits at or above `NUM_DOMAINS` read as 0 in status and mask. Command bits in those positions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid with rd_vld |
| rd_vld | output | 1 | Read data valid, one cycle after rd_en |
| pwr_req | output | NUM_DOMAINS | Per-domain power-on request |
| pwr_ack | input | NUM_DOMAINS | Per-domain switch acknowledge |
| irq | output | 1 | Completion interrupt |

## Verification
A command write changes `pwr_req` at the same edge that samples the write. The status bit and the interrupt flag change at the first edge that sees the acknowledge equal to the request. Read data arrives one cycle after the read strobe. The bench drives every input on falling edges and samples on falling edges, so each result is observed half a cycle after the edge that produced it. Read results go through a queue of expected values that is filled when the read is issued. A monitor pops an entry at each `rd_vld`. Port checks on `pwr_req` and `irq` are made either right after the write that affects them or after a settling wait. That wait is longer than the longest acknowledge delay of the switch model in the bench.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;

  // Word index of each register (byte offset >> 2)
  localparam int unsigned WIDX_ON    = 0;
  localparam int unsigned WIDX_OFF   = 1;
  localparam int unsigned WIDX_SLEEP = 2;
  localparam int unsigned WIDX_MASK  = 3;

  typedef enum logic [2:0] {
    SEL_ON,
    SEL_OFF,
    SEL_SLEEP,
    SEL_MASK,
    SEL_NONE
  } pdc_sel_e;

  function automatic pdc_sel_e decode_word(input int unsigned widx);
    pdc_sel_e s;
    case (widx)
      WIDX_ON:    s = SEL_ON;
      WIDX_OFF:   s = SEL_OFF;
      WIDX_SLEEP: s = SEL_SLEEP;
      WIDX_MASK:  s = SEL_MASK;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pdc_regif.sv
`timescale 1ns/1ps
module pdc_regif #(
  parameter int unsigned N      = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      sleep_vec,
  output logic [N-1:0]      on_cmd,
  output logic [N-1:0]      off_cmd,
  output logic              cmd_wr,
  output logic [N-1:0]      mask_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_vld
);
  import pdc_pkg::*;

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  pdc_sel_e          sel;

  assign word = addr[ADDR_W-1:2];

  always_comb sel = decode_word(int'(word));

  // Byte lanes below the word and data bits above the domain count carry nothing
  logic unused_bits;
  generate
    if (N < DATA_W) begin : g_wide
      assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:N]};
    end else begin : g_full
      assign unused_bits = ^addr[1:0];
    end
  endgenerate

  assign on_cmd  = (wr_en && sel == SEL_ON)  ? wdata[N-1:0] : '0;
  assign off_cmd = (wr_en && sel == SEL_OFF) ? wdata[N-1:0] : '0;
  assign cmd_wr  = wr_en && (sel == SEL_ON || sel == SEL_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_en && sel == SEL_MASK) begin
      mask_q <= wdata[N-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
      rdata  <= '0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) begin
        case (sel)
          SEL_SLEEP: rdata <= DATA_W'(sleep_vec);
          SEL_MASK:  rdata <= DATA_W'(mask_q);
          default:   rdata <= '0;
        endcase
      end else begin
        rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/pdc_domain.sv
`timescale 1ns/1ps
module pdc_domain (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic cmd_off,
  input  logic ack,
  output logic req,
  output logic sleep,
  output logic done,
  output logic pend_nxt
);
  logic req_q, sleep_q;
  logic req_nxt, sleep_nxt;
  logic pending;

  // A domain is pending while the requested state disagrees with the reported one:
  // request on (1) while asleep (1), or request off (0) while awake (0).
  assign pending = (req_q == sleep_q);
  assign done    = pending && (ack == req_q);

  always_comb begin
    req_nxt = req_q;
    if (cmd_on)       req_nxt = 1'b1;
    else if (cmd_off) req_nxt = 1'b0;
  end

  assign sleep_nxt = done ? ~ack : sleep_q;
  assign pend_nxt  = (req_nxt == sleep_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      sleep_q <= 1'b1;
    end else begin
      req_q   <= req_nxt;
      sleep_q <= sleep_nxt;
    end
  end

  assign req   = req_q;
  assign sleep = sleep_q;

endmodule

// File: rtl/pdc_irq.sv
`timescale 1ns/1ps
module pdc_irq #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] done_vec,
  input  logic [N-1:0] pend_nxt_vec,
  input  logic [N-1:0] mask,
  input  logic         cmd_wr,
  output logic         irq
);
  logic flag_q;
  logic set_evt;

  assign set_evt = (|(done_vec & mask)) && !(|(pend_nxt_vec & mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_evt) begin
      flag_q <= 1'b1;
    end else if (cmd_wr) begin
      flag_q <= 1'b0;
    end
  end

  assign irq = flag_q && (|mask);

endmodule

// File: rtl/pwr_domain_ctrl.sv
`timescale 1ns/1ps
module pwr_domain_ctrl #(
  parameter int unsigned NUM_DOMAINS = 8,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rd_vld,
  output logic [NUM_DOMAINS-1:0] pwr_req,
  input  logic [NUM_DOMAINS-1:0] pwr_ack,
  output logic                   irq
);
  localparam int unsigned N = NUM_DOMAINS;

  logic [N-1:0] on_cmd, off_cmd;
  logic         cmd_wr;
  logic [N-1:0] mask_vec;
  logic [N-1:0] sleep_vec;
  logic [N-1:0] done_vec;
  logic [N-1:0] pend_nxt_vec;

  pdc_regif #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .sleep_vec (sleep_vec),
    .on_cmd    (on_cmd),
    .off_cmd   (off_cmd),
    .cmd_wr    (cmd_wr),
    .mask_q    (mask_vec),
    .rdata     (rdata),
    .rd_vld    (rd_vld)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_dom
      pdc_domain u_dom (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_on   (on_cmd[i]),
        .cmd_off  (off_cmd[i]),
        .ack      (pwr_ack[i]),
        .req      (pwr_req[i]),
        .sleep    (sleep_vec[i]),
        .done     (done_vec[i]),
        .pend_nxt (pend_nxt_vec[i])
      );
    end
  endgenerate

  pdc_irq #(.N(N)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_vec     (done_vec),
    .pend_nxt_vec (pend_nxt_vec),
    .mask         (mask_vec),
    .cmd_wr       (cmd_wr),
    .irq          (irq)
  );

endmodule

// File: rtl/pdc_checker.sv
`timescale 1ns/1ps
module pdc_checker #(
  parameter int unsigned N      = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_vld,
  input logic [N-1:0]      pwr_req,
  input logic [N-1:0]      pwr_ack,
  input logic              irq,
  input logic [N-1:0]      sleep,
  input logic [N-1:0]      mask_q
);

  // R1: read data is flagged in the cycle after the strobe
  p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);

  // R2 / R3: requests move only because of a bus write
  p_req_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_req) |-> $past(wr_en));

  // R4: a status bit that changes takes the inverse of the acknowledge it saw
  p_sleep_tracks_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sleep ^ $past(sleep)) & ($past(pwr_ack) ^ ~sleep)) == '0);

  // R5: no interrupt while nothing is enabled
  p_no_irq_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  // R9: command registers read back as zero
  p_cmd_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && (int'($past(addr)) < 8)) |-> (rdata == '0));

  // R10: out-of-range reads return zero
  p_oob_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && (int'($past(addr)) >= 16)) |-> (rdata == '0));

endmodule

bind pwr_domain_ctrl pdc_checker #(
  .N(NUM_DOMAINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_pdc_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .rdata   (rdata),
  .rd_vld  (rd_vld),
  .pwr_req (pwr_req),
  .pwr_ack (pwr_ack),
  .irq     (irq),
  .sleep   (sleep_vec),
  .mask_q  (mask_vec)
);

// File: tb/pwr_domain_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_domain_ctrl_bench;
  localparam int unsigned N      = 8;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_ON = 5'h00, A_OFF = 5'h04, A_SLP = 5'h08, A_MSK = 5'h0C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              rd_vld;
  logic [N-1:0]      pwr_req;
  logic [N-1:0]      pwr_ack;
  logic              irq;

  logic [N-1:0]      hold = '0;
  logic [7:0]        cnt [N];

  int n_chk  = 0;
  int n_fail = 0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #4 clk = ~clk;

  pwr_domain_ctrl #(.NUM_DOMAINS(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pwr_domain_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_vld(rd_vld), .pwr_req(pwr_req),
    .pwr_ack(pwr_ack), .irq(irq)
  );

  // Switch model: domain i answers after 3+i cycles; hold freezes an acknowledge
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        pwr_ack[i] <= 1'b0;
        cnt[i]     <= '0;
      end else if (!hold[i]) begin
        if (pwr_ack[i] != pwr_req[i]) begin
          if (cnt[i] >= 8'(3 + i)) begin
            pwr_ack[i] <= pwr_req[i];
            cnt[i]     <= '0;
          end else begin
            cnt[i] <= cnt[i] + 8'd1;
          end
        end else begin
          cnt[i] <= '0;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected value per returned read
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected rd_vld", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    check("R11 pwr_req after reset", 32'(pwr_req), 32'h0);
    check("R11 irq after reset", 32'(irq), 32'h0);
    bus_rd(A_SLP, 32'h0000_00FF, "R11 status all asleep");
    bus_rd(A_MSK, 32'h0, "R11 mask zero");

    // R2: power on bits 0 and 2
    bus_wr(A_ON, 32'h05);
    check("R2 pwr_req after on-write", 32'(pwr_req), 32'h05);
    bus_rd(A_SLP, 32'h0000_00FF, "R4 status waits for ack");
    settle();
    bus_rd(A_SLP, 32'h0000_00FA, "R4 status after ack");
    check("R5 no irq with zero mask", 32'(irq), 32'h0);

    // R9 / R1
    bus_rd(A_ON, 32'h0, "R9 on-register reads zero");
    bus_rd(A_OFF, 32'h0, "R9 off-register reads zero");
    bus_rd(5'h0B, 32'h0000_00FA, "R1 low address bits ignored");

    // R7: completion interrupt
    bus_wr(A_MSK, 32'h0F);
    bus_rd(A_MSK, 32'h0F, "R9 mask readback");
    bus_wr(A_ON, 32'h0A);
    check("R7 irq low while pending", 32'(irq), 32'h0);
    settle();
    check("R7 irq after last masked completion", 32'(irq), 32'h1);
    bus_rd(A_SLP, 32'h0000_00F0, "R2 status after second on-write");

    // R8: command write clears the flag
    bus_wr(A_ON, 32'h00);
    check("R8 irq cleared by command write", 32'(irq), 32'h0);

    // R6: request for a state already held
    bus_wr(A_ON, 32'h01);
    check("R6 pwr_req unchanged", 32'(pwr_req), 32'h0F);
    settle();
    check("R6 no completion for no-op", 32'(irq), 32'h0);

    // R6: later command wins
    bus_wr(A_ON, 32'h10);
    bus_wr(A_OFF, 32'h10);
    check("R6 later off-write wins", 32'(pwr_req), 32'h0F);
    settle();
    bus_rd(A_SLP, 32'h0000_00F0, "R6 domain 4 never woke");

    // R12: bits above the domain count
    bus_wr(A_ON, 32'hFFFF_FF00);
    check("R12 high command bits ignored", 32'(pwr_req), 32'h0F);
    bus_wr(A_MSK, 32'hFFFF_FFFF);
    bus_rd(A_MSK, 32'h0000_00FF, "R12 mask upper bits read zero");
    bus_wr(A_MSK, 32'h0F);

    // R10: out-of-range accesses
    bus_wr(5'h10, 32'hFF);
    bus_wr(5'h1C, 32'h0);
    check("R10 out-of-range write no request change", 32'(pwr_req), 32'h0F);
    bus_rd(5'h10, 32'h0, "R10 read 0x10 zero");
    bus_rd(5'h18, 32'h0, "R10 read 0x18 zero");
    bus_rd(A_MSK, 32'h0F, "R10 mask untouched");

    // R4 / R7: a stuck acknowledge keeps status and interrupt back
    hold[2] = 1'b1;
    bus_wr(A_OFF, 32'h06);
    check("R3 off-write drops requests", 32'(pwr_req), 32'h09);
    settle();
    bus_rd(A_SLP, 32'h0000_00F2, "R4 stuck ack keeps domain 2 awake");
    check("R7 irq held by masked pending domain", 32'(irq), 32'h0);
    hold[2] = 1'b0;
    settle();
    bus_rd(A_SLP, 32'h0000_00F6, "R4 status after ack released");
    check("R7 irq after release", 32'(irq), 32'h1);

    // R3: power everything off
    bus_wr(A_OFF, 32'h09);
    check("R3 all requests low", 32'(pwr_req), 32'h0);
    check("R8 irq cleared by off-write", 32'(irq), 32'h0);
    settle();
    bus_rd(A_SLP, 32'h0000_00FF, "R3 all asleep");
    check("R7 irq after power-off", 32'(irq), 32'h1);

    // R5: clearing the mask silences the output
    bus_wr(A_MSK, 32'h0);
    check("R5 irq low with zero mask", 32'(irq), 32'h0);

    repeat (3) @(negedge clk);
    check("R1 every read answered", 32'(exp_q.size()), 32'h0);
    finish_run();
  end

endmodule